// File: doc/BRIEF.md
# Programmable Periodic Update Pulse Generator

This block decides when staged configuration takes effect. A bank of shadow words is presented on its input, and on each update event the whole bank is copied, in one clock edge, into the active bank that drives the rest of the design. Because every word moves on the same edge, no consumer ever sees half old and half new settings.

There are two sources of update events, and a mode input selects between them. In internal mode, a countdown timer that advances once every two clocks fires a transfer periodically. The block also drives a fixed-width indicator pulse out on a shared bidirectional pin. In external mode, the block releases the pin and treats it as an input. It passes the pin through a synchronizer and an edge detector, so that each rising edge from outside becomes exactly one transfer. The period value is sampled only when the timer reaches terminal count, so a new period never cuts a running interval short.

Top module: `upd_pulse_gen`

## Requirements
- R1: While reset is asserted, and right after it is released, internal mode is selected whatever the mode input shows. The pin output enable is high and every active word is zero.
- R2: In internal mode, the first transfer happens on the fourth rising clock edge after the reset input deasserts. Each later transfer comes 2*(N+1) clock edges after the previous one, where N is the period value captured at that previous transfer.
- R3: After each internal transfer with a captured N of 5 or more, the pin output is high for exactly 8 clock cycles, starting with the cycle after the transfer edge, and is low for the rest of the interval.
- R4: While the captured N is below 5 in internal mode, the pin output stays high continuously, and transfers still occur at the 2*(N+1) spacing.
- R5: A change of the period input takes effect only at the next terminal count; the interval already running keeps its old length.
- R6: In external mode, a rising edge on the pin input, set up before clock edge k, causes one transfer on edge k+2. Holding the pin high produces no further transfer.
- R7: Nothing else transfers. In external mode, falling edges and steady levels on the pin do nothing. The internal timer never fires in external mode, and a transfer due on the edge that leaves internal mode is dropped.
- R8: A change of the mode input is taken on the next clock edge. That edge clears the countdown and the pulse timer, so on entering internal mode the first transfer comes two edges after that edge.
- R9: A transfer copies every word of the shadow bank, as present at the transfer edge, into the active bank. Word i occupies bits [16*i+15:16*i] of both buses.
- R10: The pin output enable is high in internal mode and low in external mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| int_mode_i | input | 1 | 1 selects the internal timer, 0 selects the external pin |
| period_i | input | 32 | Period value N for the internal timer |
| shadow_i | input | 64 | Staged bank, four 16-bit words |
| pin_i | input | 1 | Pin level seen from outside |
| pin_o | output | 1 | Pin level driven in internal mode |
| pin_oe_o | output | 1 | Pin output enable |
| active_o | output | 64 | Active bank, four 16-bit words |

## Verification
A wrong countdown value or phase shows up as a change of active_o on the wrong edge. Because the shadow pattern changes every cycle, the same fault also shows as the wrong data, so the scoreboard catches it at the first transfer after the fault. A wrong captured period or pulse counter shows up on the pin within one interval. It appears as a pulse of the wrong length, or as a pin that stays high when it should drop, or drops when it should stay high. A bad synchronizer or mode register shows as an extra or missing transfer within three edges of the pin or mode change, or as the output enable holding the wrong level.

// File: rtl/upd_pkg.sv
package upd_pkg;
  typedef enum logic {
    SRC_EXT = 1'b0,
    SRC_INT = 1'b1
  } upd_src_e;

  localparam int unsigned UPD_PULSE_CYC  = 8;
  localparam int unsigned UPD_STICKY_MIN = 5;
endpackage

// File: rtl/upd_rst_sync.sv
module upd_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_s = chain_q[STAGES-1];
endmodule

// File: rtl/upd_edge_sync.sv
module upd_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  for (genvar g = 0; g <= STAGES; g++) begin : g_stage
    logic d;
    if (g == 0) begin : g_first
      assign d = async_i;
    end else begin : g_next
      assign d = sh_q[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q[g] <= 1'b0;
      else        sh_q[g] <= d;
    end
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

  p_single_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/upd_period_timer.sv
module upd_period_timer
  import upd_pkg::*;
#(
  parameter int unsigned CNT_W      = 32,
  parameter int unsigned PULSE_CYC  = UPD_PULSE_CYC,
  parameter int unsigned STICKY_MIN = UPD_STICKY_MIN
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] period_i,
  output logic             fire_o,
  output logic             pin_o
);
  localparam int unsigned PW_W = $clog2(PULSE_CYC + 1);

  logic             half_q, half_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] load_q, load_d;
  logic [PW_W-1:0]  pw_q, pw_d;
  logic             idle;
  logic             at_zero;

  always_comb begin
    idle    = clr_i | ~run_i;
    at_zero = (cnt_q == '0);
    fire_o  = ~idle & half_q & at_zero;

    half_d = idle ? 1'b0 : ~half_q;

    if (idle)                  cnt_d = '0;
    else if (half_q && at_zero) cnt_d = period_i;
    else if (half_q)           cnt_d = cnt_q - 1'b1;
    else                       cnt_d = cnt_q;

    load_d = fire_o ? period_i : load_q;

    if (idle)             pw_d = '0;
    else if (fire_o)      pw_d = PW_W'(PULSE_CYC);
    else if (pw_q != '0)  pw_d = pw_q - 1'b1;
    else                  pw_d = pw_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= 1'b0;
      cnt_q  <= '0;
      load_q <= '0;
      pw_q   <= '0;
    end else begin
      half_q <= half_d;
      cnt_q  <= cnt_d;
      load_q <= load_d;
      pw_q   <= pw_d;
    end
  end

  assign pin_o = run_i & ((pw_q != '0) | (load_q < CNT_W'(STICKY_MIN)));

  p_pin_after_fire_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |=> (pin_o || !run_i));

  p_fire_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |=> !fire_o);
endmodule

// File: rtl/upd_reg_bank.sv
module upd_reg_bank #(
  parameter int unsigned NREGS = 4,
  parameter int unsigned REG_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load_i,
  input  logic [NREGS*REG_W-1:0] shadow_i,
  output logic [NREGS*REG_W-1:0] active_o
);
  for (genvar g = 0; g < NREGS; g++) begin : g_word
    logic [REG_W-1:0] word_d, word_q;
    always_comb begin
      word_d = load_i ? shadow_i[g*REG_W +: REG_W] : word_q;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q <= '0;
      else        word_q <= word_d;
    end
    assign active_o[g*REG_W +: REG_W] = word_q;
  end

  p_copy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (active_o == $past(shadow_i)));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(active_o));
endmodule

// File: rtl/upd_pulse_gen.sv
module upd_pulse_gen
  import upd_pkg::*;
#(
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned NREGS       = 4,
  parameter int unsigned REG_W       = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned PULSE_CYC   = UPD_PULSE_CYC,
  parameter int unsigned STICKY_MIN  = UPD_STICKY_MIN
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   int_mode_i,
  input  logic [CNT_W-1:0]       period_i,
  input  logic [NREGS*REG_W-1:0] shadow_i,
  input  logic                   pin_i,
  output logic                   pin_o,
  output logic                   pin_oe_o,
  output logic [NREGS*REG_W-1:0] active_o
);
  localparam int unsigned BANK_W = NREGS * REG_W;

  logic     rst_n_s;
  upd_src_e mode_q, mode_d;
  logic     mode_chg;
  logic     run;
  logic     tmr_fire;
  logic     ext_rise;
  logic     xfer;
  logic     tmr_pin;

  upd_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  always_comb begin
    mode_d   = upd_src_e'(int_mode_i);
    mode_chg = (mode_d != mode_q);
    run      = (mode_q == SRC_INT);
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) mode_q <= SRC_INT;
    else          mode_q <= mode_d;
  end

  upd_period_timer #(
    .CNT_W      (CNT_W),
    .PULSE_CYC  (PULSE_CYC),
    .STICKY_MIN (STICKY_MIN)
  ) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .run_i    (run),
    .clr_i    (mode_chg),
    .period_i (period_i),
    .fire_o   (tmr_fire),
    .pin_o    (tmr_pin)
  );

  upd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .async_i (pin_i),
    .rise_o  (ext_rise)
  );

  always_comb begin
    xfer = run ? tmr_fire : ext_rise;
  end

  upd_reg_bank #(
    .NREGS (NREGS),
    .REG_W (REG_W)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .load_i   (xfer),
    .shadow_i (shadow_i[BANK_W-1:0]),
    .active_o (active_o)
  );

  assign pin_o    = tmr_pin;
  assign pin_oe_o = run;

  p_ext_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mode_q == SRC_EXT) |-> !tmr_fire);

  p_ext_pin_low_r10: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mode_q == SRC_EXT) |-> !pin_o);
endmodule

// File: tb/sim_upd_pulse_gen.sv
module sim_upd_pulse_gen;
  localparam int BW = 64;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          int_mode;
  logic [31:0]   period;
  logic [BW-1:0] shadow;
  logic          ext_pin;
  logic          pin_i, pin_o, pin_oe;
  logic [BW-1:0] active;

  int cyc = -2;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [BW-1:0] prev_active = '0;

  typedef struct {
    int            edge_no;
    logic [BW-1:0] data;
    string         req;
  } exp_t;
  exp_t sbq[$];

  always #5 clk = ~clk;

  assign pin_i = pin_oe ? pin_o : ext_pin;

  upd_pulse_gen u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .int_mode_i (int_mode),
    .period_i   (period),
    .shadow_i   (shadow),
    .pin_i      (pin_i),
    .pin_o      (pin_o),
    .pin_oe_o   (pin_oe),
    .active_o   (active)
  );

  function automatic logic [BW-1:0] pat(int c);
    logic [BW-1:0] r;
    for (int i = 0; i < 4; i++) r[i*16 +: 16] = 16'(c * 7 + i * 3 + 1);
    return r;
  endfunction

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s at cycle %0d: actual %0h expected %0h", req, what, cyc, act, exp);
    end
  endtask

  task automatic push_exp(int e, string req);
    exp_t x;
    x.edge_no = e;
    x.data    = pat(e - 1);
    x.req     = req;
    sbq.push_back(x);
  endtask

  always @(posedge clk) begin
    if (!rst_n) cyc <= -2;
    else        cyc <= cyc + 1;
  end

  // shadow changes every cycle so transfer timing shows in the data
  always @(negedge clk) shadow = pat(cyc);

  // monitor: every change of the active bank must match the next expected item
  always @(negedge clk) begin
    if (rst_n && cyc >= 1 && !done) begin
      if (active !== prev_active) begin
        if (sbq.size() == 0) begin
          check(1'b0, "R7", "unexpected transfer", active, prev_active);
        end else begin
          exp_t e;
          e = sbq.pop_front();
          check(cyc == e.edge_no, e.req, "transfer edge", 64'(cyc), 64'(e.edge_no));
          check(active === e.data, "R9", "transferred bank", active, e.data);
        end
        prev_active = active;
      end
    end
  end

  initial begin
    rst_n    = 1'b0;
    int_mode = 1'b0;
    period   = 32'd9;
    ext_pin  = 1'b0;
    repeat (3) @(negedge clk);
    check(pin_oe === 1'b1, "R1", "oe in reset", 64'(pin_oe), 64'd1);
    check(active === '0, "R1", "active in reset", active, '0);
    int_mode = 1'b1;
    push_exp(2, "R2");   push_exp(22, "R2");  push_exp(42, "R2");
    push_exp(62, "R5");  push_exp(76, "R5");  push_exp(90, "R5");
    push_exp(104, "R5"); push_exp(110, "R4"); push_exp(116, "R4");
    push_exp(122, "R4"); push_exp(128, "R4"); push_exp(143, "R6");
    push_exp(163, "R6"); push_exp(173, "R8"); push_exp(189, "R8");
    push_exp(205, "R8");
    rst_n = 1'b1;
    while (cyc < 212) begin
      @(negedge clk);
      if (cyc == 45)  period   = 32'd6;
      if (cyc == 95)  period   = 32'd2;
      if (cyc == 131) int_mode = 1'b0;
      if (cyc == 140) ext_pin  = 1'b1;
      if (cyc == 150) ext_pin  = 1'b0;
      if (cyc == 160) ext_pin  = 1'b1;
      if (cyc == 165) period   = 32'd7;
      if (cyc == 170) int_mode = 1'b1;
      if (cyc == 1)
        check(pin_oe === 1'b1, "R1", "oe after reset", 64'(pin_oe), 64'd1);
      if (cyc >= 10 && cyc <= 41)
        check(pin_o === (cyc >= 22 && cyc <= 29), "R3", "pin pulse N=9",
              64'(pin_o), 64'(cyc >= 22 && cyc <= 29));
      if (cyc >= 105 && cyc <= 131)
        check(pin_o === 1'b1, "R4", "pin held high N=2", 64'(pin_o), 64'd1);
      if (cyc == 60)
        check(pin_oe === 1'b1, "R10", "oe internal", 64'(pin_oe), 64'd1);
      if (cyc >= 132 && cyc <= 170)
        check(pin_oe === 1'b0, "R10", "oe external", 64'(pin_oe), 64'd0);
      if (cyc == 158)
        check(active === pat(142), "R7", "no transfer on falling edge", active, pat(142));
      if (cyc >= 173 && cyc <= 188)
        check(pin_o === (cyc <= 180), "R3", "pin pulse after restart",
              64'(pin_o), 64'(cyc <= 180));
    end
    check(sbq.size() == 0, "R2", "missing transfers", 64'(sbq.size()), 64'd0);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL R2 watchdog expired: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule